// File: doc/BRIEF.md
# Mask Register Right-Shift Unit

This unit executes the immediate-count right shift on a 64-bit mask register. Each accepted instruction supplies an opcode byte, a W bit, a ModRM byte and an 8-bit immediate. The opcode and W bit together pick an operating width of 8, 16, 32 or 64 bits. ModRM.r/m names the source mask and ModRM.reg names the destination. The unit reads the source from an internal file of eight 64-bit mask registers and keeps only the low bits of the operating width. It shifts them right logically by the immediate and writes the result, zero-extended to 64 bits, back into the file.

The count is the whole immediate, not a value reduced modulo the width. Any count at or above the operating width therefore gives an all-zero result. Encodings that are not register-to-register forms, and opcodes outside the pair this unit owns, raise a one-cycle illegal flag and leave the file untouched. Other mask units in the core share the same file through a second write port. When both writers target the same register on one edge, the shift writeback wins.

Top module: `mskshr_unit`

## Requirements
- R1: The opcode byte and W bit set the width: 0x30/W=0 gives 8 bits, 0x30/W=1 gives 16 bits, 0x31/W=0 gives 32 bits, 0x31/W=1 gives 64 bits.
- R2: The count is the full 8-bit immediate. When it is greater than or equal to the operating width, all 64 bits of the result are zero (for example, count 8 in 8-bit mode and count 0x88 in any mode below 64 bits).
- R3: When the count is below the width, result bit i equals source bit i+count if i+count is below the width, and 0 otherwise.
- R4: Every result bit at or above the operating width is zero, whatever the source holds there.
- R5: The destination index is ModRM bits [5:3]. The source index is ModRM bits [2:0].
- R6: If ModRM bits [7:6] are not 11b, illegal_o is high for exactly the following cycle, wb_valid_o stays low, and no register changes.
- R7: An opcode other than 0x30 or 0x31 is handled in the same way as R6.
- R8: wb_valid_o, wb_idx_o and wb_data_o are presented in the cycle after the valid input. A cycle with in_valid low is followed by a cycle with wb_valid_o and illegal_o both low.
- R9: A synchronous active-high reset clears all eight mask registers and both output flags.
- R10: An instruction whose source is a register being written on the same edge reads the value held before that write.
- R11: The side write port (ext_we, ext_idx, ext_data) loads a register on the next edge. If it targets the same register as a legal shift writeback on that edge, the shift result is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_wbit | input | 1 | W bit of the prefix |
| in_modrm | input | 8 | ModRM byte |
| in_imm | input | 8 | Shift count immediate |
| ext_we | input | 1 | Side write enable from other mask units |
| ext_idx | input | 3 | Side write register index |
| ext_data | input | 64 | Side write data |
| illegal_o | output | 1 | Illegal encoding seen on the previous cycle |
| wb_valid_o | output | 1 | Writeback valid |
| wb_idx_o | output | 3 | Destination register written |
| wb_data_o | output | 64 | Value written |

## Verification
A register file entry that holds a wrong value stays hidden until a later shift reads that entry. It then shows up on wb_data_o one cycle after that instruction. For this reason the bench keeps its own copy of the file and reads registers back with a 64-bit shift by zero after illegal forms and write collisions. A decode that picks the wrong width or index is visible on the very next cycle, in wb_data_o or wb_idx_o. A stuck illegal path shows at once as a wrong illegal_o or wb_valid_o level.

// File: rtl/mskshr_pkg.sv
package mskshr_pkg;

  typedef enum logic [1:0] {
    MODE_B8  = 2'd0,
    MODE_W16 = 2'd1,
    MODE_D32 = 2'd2,
    MODE_Q64 = 2'd3
  } shr_mode_e;

  typedef struct packed {
    logic      legal;
    logic      bad_mod;
    logic      bad_opc;
    shr_mode_e mode;
    logic [2:0] dst;
    logic [2:0] src;
    logic [7:0] count;
  } shr_dec_t;

  // operating width of a mode, given the full mask width
  function automatic int unsigned mode_width(input shr_mode_e m, input int unsigned full_w);
    return full_w >> (3 - int'(m));
  endfunction

endpackage

// File: rtl/mskshr_decode.sv
module mskshr_decode
  import mskshr_pkg::*;
#(
  parameter logic [7:0] OPC_NARROW = 8'h30,
  parameter logic [7:0] OPC_WIDE   = 8'h31
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] opcode,
  input  logic       wbit,
  input  logic [7:0] modrm,
  input  logic [7:0] imm,
  output shr_dec_t   dec_o
);

  logic opc_narrow, opc_wide, mod_reg_form;

  assign opc_narrow   = (opcode == OPC_NARROW);
  assign opc_wide     = (opcode == OPC_WIDE);
  assign mod_reg_form = (modrm[7:6] == 2'b11);

  always_comb begin
    dec_o         = '0;
    dec_o.bad_mod = !mod_reg_form;
    dec_o.bad_opc = !(opc_narrow || opc_wide);
    dec_o.legal   = mod_reg_form && (opc_narrow || opc_wide);
    dec_o.dst     = modrm[5:3];
    dec_o.src     = modrm[2:0];
    dec_o.count   = imm;
    unique case ({opc_wide, wbit})
      2'b00:   dec_o.mode = MODE_B8;
      2'b01:   dec_o.mode = MODE_W16;
      2'b10:   dec_o.mode = MODE_D32;
      default: dec_o.mode = MODE_Q64;
    endcase
  end

  // R1: the narrow opcode only picks the 8/16 modes, and W chooses between them
  p_narrow_modes_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_o.legal && opcode == OPC_NARROW) |->
      (dec_o.mode == (wbit ? MODE_W16 : MODE_B8)));

  p_wide_modes_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_o.legal && opcode == OPC_WIDE) |->
      (dec_o.mode == (wbit ? MODE_Q64 : MODE_D32)));

  // R6: memory forms never decode as legal
  p_mod_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && modrm[7:6] != 2'b11) |-> !dec_o.legal);

  // R7: foreign opcodes never decode as legal
  p_opc_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode != OPC_NARROW && opcode != OPC_WIDE) |-> !dec_o.legal);

endmodule

// File: rtl/mskshr_shifter.sv
module mskshr_shifter
  import mskshr_pkg::*;
#(
  parameter int unsigned MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] src,
  input  logic [7:0]        count,
  input  shr_mode_e         mode,
  output logic [MASK_W-1:0] result,
  output logic              over_range
);

  localparam int unsigned N_MODES = 4;

  // keep the low lw bits of s, then shift right by c; zero once c reaches lw
  function automatic logic [MASK_W-1:0] lane_shr(
    input logic [MASK_W-1:0] s,
    input logic [7:0]        c,
    input int unsigned       lw
  );
    logic [MASK_W-1:0] keep;
    keep = (lw >= MASK_W) ? '1 : ((MASK_W'(1) << lw) - MASK_W'(1));
    if ({24'd0, c} >= lw) return '0;
    return (s & keep) >> c;
  endfunction

  function automatic logic [MASK_W-1:0] low_mask(input int unsigned lw);
    return (lw >= MASK_W) ? '1 : ((MASK_W'(1) << lw) - MASK_W'(1));
  endfunction

  logic [N_MODES-1:0][MASK_W-1:0] lane_res;
  logic [N_MODES-1:0][MASK_W-1:0] lane_mask;
  logic [N_MODES-1:0]             lane_over;
  logic [MASK_W-1:0]              width_mask;

  for (genvar g = 0; g < N_MODES; g++) begin : g_lane
    localparam int unsigned LANE_W = MASK_W >> (N_MODES - 1 - g);
    assign lane_res[g]  = lane_shr(src, count, LANE_W);
    assign lane_mask[g] = low_mask(LANE_W);
    assign lane_over[g] = ({24'd0, count} >= LANE_W);
  end

  assign result     = lane_res[mode];
  assign width_mask = lane_mask[mode];
  assign over_range = lane_over[mode];

  // R2: a count at or past the width clears the whole result
  p_over_zero_r2: assert property (@(posedge clk) disable iff (rst)
    over_range |-> (result == '0));

  // R4: nothing survives above the operating width
  p_high_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ((result & ~width_mask) == '0));

  // R3: a zero count passes the in-width bits through unchanged
  p_zero_count_r3: assert property (@(posedge clk) disable iff (rst)
    (count == 8'd0) |-> (result == (src & width_mask)));

endmodule

// File: rtl/mskshr_regfile.sv
module mskshr_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned MASK_W = 64,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [MASK_W-1:0] rd_data,
  input  logic              sh_we,
  input  logic [IDX_W-1:0]  sh_idx,
  input  logic [MASK_W-1:0] sh_data,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [MASK_W-1:0] ext_data
);

  logic [NREG-1:0][MASK_W-1:0] regs_q;
  logic [NREG-1:0]             hit_sh, hit_ext;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign hit_sh[r]  = sh_we  && (sh_idx  == IDX_W'(r));
    assign hit_ext[r] = ext_we && (ext_idx == IDX_W'(r));
    always_ff @(posedge clk) begin
      if (rst)            regs_q[r] <= '0;
      else if (hit_sh[r]) regs_q[r] <= sh_data;
      else if (hit_ext[r]) regs_q[r] <= ext_data;
    end
  end

  assign rd_data = regs_q[rd_idx];

  // R11: on a shared index the shift writeback is the value kept
  p_shift_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (sh_we && ext_we && sh_idx == ext_idx) |=> (regs_q[$past(sh_idx)] == $past(sh_data)));

  // R11: a lone side write lands on the next edge
  p_ext_lands_r11: assert property (@(posedge clk) disable iff (rst)
    (ext_we && !(sh_we && sh_idx == ext_idx)) |=> (regs_q[$past(ext_idx)] == $past(ext_data)));

  // R6/R7: with no writer the file holds still
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!sh_we && !ext_we) |=> $stable(regs_q));

endmodule

// File: rtl/mskshr_unit.sv
module mskshr_unit
  import mskshr_pkg::*;
#(
  parameter int unsigned NREG       = 8,
  parameter int unsigned MASK_W     = 64,
  parameter logic [7:0]  OPC_NARROW = 8'h30,
  parameter logic [7:0]  OPC_WIDE   = 8'h31,
  localparam int unsigned IDX_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic              in_wbit,
  input  logic [7:0]        in_modrm,
  input  logic [7:0]        in_imm,
  input  logic              ext_we,
  input  logic [IDX_W-1:0]  ext_idx,
  input  logic [MASK_W-1:0] ext_data,
  output logic              illegal_o,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [MASK_W-1:0] wb_data_o
);

  shr_dec_t          dec;
  logic [MASK_W-1:0] src_val, shr_val;
  logic              shr_over;
  logic              do_write, do_flag;
  logic [IDX_W-1:0]  dst_idx, src_idx;

  mskshr_decode #(
    .OPC_NARROW (OPC_NARROW),
    .OPC_WIDE   (OPC_WIDE)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .opcode   (in_opcode),
    .wbit     (in_wbit),
    .modrm    (in_modrm),
    .imm      (in_imm),
    .dec_o    (dec)
  );

  assign dst_idx  = dec.dst[IDX_W-1:0];
  assign src_idx  = dec.src[IDX_W-1:0];
  assign do_write = in_valid && dec.legal;
  assign do_flag  = in_valid && !dec.legal;

  mskshr_regfile #(
    .NREG   (NREG),
    .MASK_W (MASK_W)
  ) u_regfile (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (src_idx),
    .rd_data  (src_val),
    .sh_we    (do_write),
    .sh_idx   (dst_idx),
    .sh_data  (shr_val),
    .ext_we   (ext_we),
    .ext_idx  (ext_idx),
    .ext_data (ext_data)
  );

  mskshr_shifter #(
    .MASK_W (MASK_W)
  ) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .src        (src_val),
    .count      (dec.count),
    .mode       (dec.mode),
    .result     (shr_val),
    .over_range (shr_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_o <= 1'b0;
      illegal_o  <= 1'b0;
      wb_idx_o   <= '0;
      wb_data_o  <= '0;
    end else begin
      wb_valid_o <= do_write;
      illegal_o  <= do_flag;
      if (do_write) begin
        wb_idx_o  <= dst_idx;
        wb_data_o <= shr_val;
      end
    end
  end

  // R8: legal input shows as a writeback one cycle later, with its destination
  p_wb_next_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.legal) |=> (wb_valid_o && !illegal_o && wb_idx_o == $past(dst_idx)));

  // R8: an idle cycle leaves both flags low afterwards
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wb_valid_o && !illegal_o));

  // R6/R7: illegal forms flag and never write back
  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec.legal) |=> (illegal_o && !wb_valid_o));

  // R2: an out-of-range count reaches the port as zero
  p_over_wb_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.legal && shr_over) |=> (wb_data_o == '0));

  // R6: the two flags are never both raised
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(illegal_o && wb_valid_o));

endmodule

// File: tb/mskshr_unit_tb_top.sv
module mskshr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_opcode;
  logic        in_wbit;
  logic [7:0]  in_modrm;
  logic [7:0]  in_imm;
  logic        ext_we;
  logic [2:0]  ext_idx;
  logic [63:0] ext_data;
  logic        illegal_o;
  logic        wb_valid_o;
  logic [2:0]  wb_idx_o;
  logic [63:0] wb_data_o;

  int checks   = 0;
  int failures = 0;
  logic [63:0] mdl [8];

  always #5 clk = ~clk;

  mskshr_unit dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_opcode  (in_opcode),
    .in_wbit    (in_wbit),
    .in_modrm   (in_modrm),
    .in_imm     (in_imm),
    .ext_we     (ext_we),
    .ext_idx    (ext_idx),
    .ext_data   (ext_data),
    .illegal_o  (illegal_o),
    .wb_valid_o (wb_valid_o),
    .wb_idx_o   (wb_idx_o),
    .wb_data_o  (wb_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [7:0] opc, input bit w);
    if (opc == 8'h30) return w ? 16 : 8;
    return w ? 64 : 32;
  endfunction

  // bitwise restatement of the shift rule
  function automatic logic [63:0] exp_shift(input logic [63:0] s, input logic [7:0] opc,
                                           input bit w, input logic [7:0] c);
    logic [63:0] o;
    int wd;
    wd = width_of(opc, w);
    o  = '0;
    for (int i = 0; i < 64; i++)
      if (i + int'(c) < wd) o[i] = s[i + int'(c)];
    return o;
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic run_op(input logic [7:0] opc, input bit w, input logic [7:0] mrm,
                        input logic [7:0] imm, input bit xwe, input logic [2:0] xidx,
                        input logic [63:0] xd, input string tag);
    bit legal;
    logic [63:0] exp;
    legal = (mrm[7:6] == 2'b11) && (opc == 8'h30 || opc == 8'h31);
    exp   = legal ? exp_shift(mdl[mrm[2:0]], opc, w, imm) : '0;
    in_valid = 1'b1; in_opcode = opc; in_wbit = w; in_modrm = mrm; in_imm = imm;
    ext_we = xwe; ext_idx = xidx; ext_data = xd;
    if (xwe) mdl[xidx] = xd;
    if (legal) mdl[mrm[5:3]] = exp;
    @(negedge clk);
    in_valid = 1'b0; ext_we = 1'b0;
    if (legal) begin
      chk(wb_valid_o && !illegal_o, {tag, " R8 valid"}, {62'd0, illegal_o, wb_valid_o}, 64'd1);
      chk(wb_idx_o == mrm[5:3], {tag, " R5 dst index"}, 64'(wb_idx_o), 64'(mrm[5:3]));
      chk(wb_data_o == exp, {tag, " R3 data"}, wb_data_o, exp);
    end else begin
      chk(illegal_o && !wb_valid_o, {tag, " R6/R7 illegal flag"},
          {62'd0, illegal_o, wb_valid_o}, 64'd2);
    end
  endtask

  task automatic read_reg(input int r, input string tag);
    run_op(8'h31, 1'b1, {2'b11, 3'(r), 3'(r)}, 8'd0, 1'b0, 3'd0, 64'd0, tag);
  endtask

  task automatic ext_load(input int r, input logic [63:0] v);
    ext_we = 1'b1; ext_idx = 3'(r); ext_data = v;
    mdl[r] = v;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    void'($urandom(32'h5EED_0A17));
    rst = 1'b1; in_valid = 1'b0; in_opcode = '0; in_wbit = 1'b0; in_modrm = '0;
    in_imm = '0; ext_we = 1'b0; ext_idx = '0; ext_data = '0;
    for (int r = 0; r < 8; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    // R9: outputs low during reset
    chk(!wb_valid_o && !illegal_o, "R9 flags in reset", {62'd0, illegal_o, wb_valid_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!wb_valid_o && !illegal_o, "R8 idle after reset", {62'd0, illegal_o, wb_valid_o}, 64'd0);
    // R9: every register reads back as zero
    for (int r = 0; r < 8; r++) begin
      read_reg(r, "R9 reset contents");
      chk(wb_data_o == 64'd0, "R9 reg zero", wb_data_o, 64'd0);
    end

    pat = 64'hF0E1_D2C3_B4A5_9687;
    for (int r = 0; r < 8; r++) ext_load(r, pat ^ (64'(r) * 64'h0101_0101_0101_0101));
    // R11: side loads landed
    for (int r = 0; r < 8; r++) read_reg(r, "R11 side load");

    // R1/R2/R3/R4: each mode at the count boundaries
    for (int m = 0; m < 4; m++) begin
      logic [7:0] opc;
      bit w;
      int wd;
      opc = (m < 2) ? 8'h30 : 8'h31;
      w   = (m % 2) == 1;
      wd  = width_of(opc, w);
      ext_load(1, 64'hFFFF_FFFF_FFFF_FFFF);
      run_op(opc, w, 8'b11_010_001, 8'd0, 1'b0, 3'd0, 64'd0, "R1 R4 count 0");
      run_op(opc, w, 8'b11_010_001, 8'd1, 1'b0, 3'd0, 64'd0, "R3 count 1");
      run_op(opc, w, 8'b11_010_001, 8'(wd - 1), 1'b0, 3'd0, 64'd0, "R3 count w-1");
      chk(wb_data_o == 64'd1, "R3 top bit lands at 0", wb_data_o, 64'd1);
      run_op(opc, w, 8'b11_010_001, 8'(wd), 1'b0, 3'd0, 64'd0, "R2 count w");
      chk(wb_data_o == 64'd0, "R2 count equals width", wb_data_o, 64'd0);
      run_op(opc, w, 8'b11_010_001, 8'hFF, 1'b0, 3'd0, 64'd0, "R2 count 255");
      chk(wb_data_o == 64'd0, "R2 count 255 zero", wb_data_o, 64'd0);
    end
    // R2: 0x88 would be 0 mod 8; must still clear in byte mode
    run_op(8'h30, 1'b0, 8'b11_011_001, 8'h88, 1'b0, 3'd0, 64'd0, "R2 byte 0x88");
    chk(wb_data_o == 64'd0, "R2 no modulo", wb_data_o, 64'd0);

    // R6: memory form leaves destination alone
    run_op(8'h31, 1'b1, 8'b10_100_001, 8'd0, 1'b0, 3'd0, 64'd0, "R6 mod 10");
    read_reg(4, "R6 dst unchanged");
    run_op(8'h30, 1'b0, 8'b00_101_001, 8'd0, 1'b0, 3'd0, 64'd0, "R6 mod 00");
    read_reg(5, "R6 dst unchanged");
    // R7: foreign opcode
    run_op(8'h32, 1'b1, 8'b11_110_001, 8'd0, 1'b0, 3'd0, 64'd0, "R7 opcode 32");
    read_reg(6, "R7 dst unchanged");
    @(negedge clk);
    chk(!illegal_o && !wb_valid_o, "R6 flag lasts one cycle", {62'd0, illegal_o, wb_valid_o}, 64'd0);

    // R10: source equals destination, old value used
    ext_load(7, 64'h8000_0000_0000_00F0);
    run_op(8'h31, 1'b1, 8'b11_111_111, 8'd4, 1'b0, 3'd0, 64'd0, "R10 self shift");
    run_op(8'h31, 1'b1, 8'b11_111_111, 8'd4, 1'b0, 3'd0, 64'd0, "R10 back to back");
    // R11: collision on register 2, shift wins
    run_op(8'h31, 1'b0, 8'b11_010_111, 8'd1, 1'b1, 3'd2, 64'hDEAD_BEEF_DEAD_BEEF, "R11 collide");
    read_reg(2, "R11 shift kept");
    // R11: side write to another index in the same cycle
    run_op(8'h30, 1'b1, 8'b11_000_111, 8'd2, 1'b1, 3'd3, 64'h1234_5678_9ABC_DEF0, "R11 parallel");
    read_reg(3, "R11 parallel lands");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] opc, mrm, imm;
      bit w, xwe;
      int sel;
      sel = int'($urandom % 16);
      opc = (sel < 7) ? 8'h30 : (sel < 14) ? 8'h31 : 8'($urandom);
      w   = 1'($urandom);
      mrm = 8'($urandom);
      if (($urandom % 8) != 0) mrm[7:6] = 2'b11;
      imm = (($urandom % 3) == 0) ? 8'($urandom) : 8'($urandom % 70);
      xwe = (($urandom % 4) == 0);
      if (($urandom % 5) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk(!wb_valid_o && !illegal_o, "R8 random idle", {62'd0, illegal_o, wb_valid_o}, 64'd0);
      end
      run_op(opc, w, mrm, imm, xwe, 3'($urandom), {$urandom, $urandom}, "random");
    end
    for (int r = 0; r < 8; r++) read_reg(r, "R5 final contents");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule